// File: doc/BRIEF.md
# Dataflow-Synchronizing Register File

This block is a register file in which every entry holds more than data. Each entry also carries a synchronization state, a list of threads waiting for it (given by head and tail thread IDs) and metadata for an outstanding load. There are two banks, one for integer registers and one for float registers. A type bit on every access selects the bank. Writers can be the pipeline, long-latency units or the memory system, and they reach the file through several write ports. Each write is checked against the entry's current state. Writes that pass the checks are gathered during the cycle and applied together at the clock edge.

When a write fills an entry whose waiters are still parked, the block asks an external scheduler to wake the whole list. If the scheduler refuses, the write stalls on its port until the scheduler accepts. A remote read port serves other cores: it returns real data only from a filled entry, and returns zero (still treated as valid data) from any other entry while raising a warning. A lookup port shows the full contents of one entry, including state, wait list and metadata. All error flags and the warning are sticky until cleared.

Top module: `dfsync_regfile`

## Requirements
- R1: After reset every entry is EMPTY (code 0) with zero data, zero metadata and head and tail equal to the invalid thread ID (all ones). `err_o`, `warn_o`, `wake_valid_o` and `rrd_valid_o` are all 0.
- R2: An accepted write is visible on the lookup port from the next cycle: state, data, head, tail and metadata. State codes are EMPTY=0, PENDING=1, WAITING=2, FULL=3. Type bit 0 selects the integer bank and 1 selects the float bank. Each bank is independent of the other.
- R3: A FULL write to a WAITING entry whose head is valid drives `wake_valid_o` in the same cycle, with that entry's head and tail. While `wake_ready_i` is low, the port's `wr_ready_o` is 0 and the entry stays unchanged. When `wake_ready_i` is high, the write commits.
- R4: Writing EMPTY into a WAITING entry sets `err_o[1]` and leaves the entry unchanged.
- R5: A write carrying EMPTY or PENDING together with a valid head sets `err_o[2]` and is dropped.
- R6: While an entry is not FULL and its metadata is non-zero, a write that changes the metadata or sets FULL is dropped and sets `err_o[3]`, unless `wr_mem_i` marks it as coming from memory.
- R7: An index at or beyond the size of the selected bank sets `err_o[0]` and writes nothing. The lookup port shows such an index as EMPTY with zero data.
- R8: If two ports write the same register in one cycle, the lower-numbered port commits. The higher-numbered port is dropped and sets `err_o[4]`.
- R9: A remote read answers one cycle after the request. It returns the data of a FULL entry. For any other entry it returns zero and sets `warn_o`.
- R10: Error bits and `warn_o` stay set until `clr_err_i` is asserted. A clear takes priority over any new error in the same cycle.
- R11: A FULL write to a WAITING entry whose head is invalid raises no wake request and commits at once.
- R12: When an entry is FULL, it accepts any new state that passes the range, duplicate and head checks, including EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | NWP | Write request per port |
| wr_type_i | input | NWP | Bank select per port (0 integer, 1 float) |
| wr_idx_i | input | NWP*IDX_W | Register index per port |
| wr_state_i | input | NWP*2 | New synchronization state per port |
| wr_data_i | input | NWP*DATA_W | New data per port |
| wr_head_i | input | NWP*TID_W | New wait-list head per port |
| wr_tail_i | input | NWP*TID_W | New wait-list tail per port |
| wr_meta_i | input | NWP*META_W | New load metadata per port |
| wr_mem_i | input | NWP | Write comes from the memory path |
| wr_ready_o | output | NWP | Port not stalled this cycle |
| wake_valid_o | output | 1 | Wake request for a wait list |
| wake_ready_i | input | 1 | Scheduler accepts the wake request |
| wake_head_o | output | TID_W | Head of the list to wake |
| wake_tail_o | output | TID_W | Tail of the list to wake |
| rrd_req_i | input | 1 | Remote read request |
| rrd_type_i | input | 1 | Remote read bank select |
| rrd_idx_i | input | IDX_W | Remote read index |
| rrd_valid_o | output | 1 | Remote read response valid |
| rrd_data_o | output | DATA_W | Remote read data, zero if the entry is not FULL |
| lk_type_i | input | 1 | Lookup bank select |
| lk_idx_i | input | IDX_W | Lookup index |
| lk_state_o | output | 2 | Looked-up state |
| lk_data_o | output | DATA_W | Looked-up data |
| lk_head_o | output | TID_W | Looked-up wait-list head |
| lk_tail_o | output | TID_W | Looked-up wait-list tail |
| lk_meta_o | output | META_W | Looked-up load metadata |
| clr_err_i | input | 1 | Clear sticky error and warning flags |
| err_o | output | 5 | Sticky errors: 0 range, 1 illegal reset, 2 head, 3 metadata, 4 duplicate |
| warn_o | output | 1 | Sticky remote-read-of-unfilled warning |

## Verification
The hardest case to reach is a fill stalled by a refused wake-up. The entry must first be parked as WAITING with a valid head. The FULL write must then be held on its port while `wake_ready_i` stays low, and the stimulus must show that the entry has not moved before the scheduler finally accepts. The bench builds this in three steps. It first commits a WAITING write. It then presents the fill with the wake handshake refused for one full clock edge and checks the lookup port. Finally it raises `wake_ready_i` and watches the commit. Metadata protection needs a similar prepared state: a PENDING entry with non-zero metadata. Against that entry the bench sends one write from an ordinary writer and one from the memory path.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_PENDING = 2'd1,
    ST_WAITING = 2'd2,
    ST_FULL    = 2'd3
  } sync_st_e;

  localparam int ERR_W       = 5;
  localparam int ERR_RANGE   = 0;
  localparam int ERR_ILLEGAL = 1;
  localparam int ERR_HEAD    = 2;
  localparam int ERR_META    = 3;
  localparam int ERR_DUP     = 4;
endpackage

// File: rtl/srf_bank.sv
module srf_bank
  import srf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int TID_W  = 4,
  parameter int META_W = 4,
  parameter int NWP    = 2,
  parameter int NRD    = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NWP-1:0]                 we_i,
  input  logic [NWP-1:0][IDX_W-1:0]      widx_i,
  input  logic [NWP-1:0][1:0]            wstate_i,
  input  logic [NWP-1:0][DATA_W-1:0]     wdata_i,
  input  logic [NWP-1:0][TID_W-1:0]      whead_i,
  input  logic [NWP-1:0][TID_W-1:0]      wtail_i,
  input  logic [NWP-1:0][META_W-1:0]     wmeta_i,
  input  logic [NRD-1:0][IDX_W-1:0]      ridx_i,
  output logic [NRD-1:0][1:0]            rstate_o,
  output logic [NRD-1:0][DATA_W-1:0]     rdata_o,
  output logic [NRD-1:0][TID_W-1:0]      rhead_o,
  output logic [NRD-1:0][TID_W-1:0]      rtail_o,
  output logic [NRD-1:0][META_W-1:0]     rmeta_o,
  input  logic [IDX_W-1:0]               qidx_i,
  output logic [1:0]                     qstate_o,
  output logic [DATA_W-1:0]              qdata_o
);
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [1:0]        st_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TID_W-1:0]  head_q [DEPTH];
  logic [TID_W-1:0]  tail_q [DEPTH];
  logic [META_W-1:0] meta_q [DEPTH];

  function automatic logic in_rng(input logic [IDX_W-1:0] idx);
    return {1'b0, idx} < DEPTH_L;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) begin
        st_q[e]   <= ST_EMPTY;
        data_q[e] <= '0;
        head_q[e] <= '1;
        tail_q[e] <= '1;
        meta_q[e] <= '0;
      end
    end else begin
      // commit queue: one slot per write port, all applied at the edge
      for (int p = 0; p < NWP; p++) begin
        if (we_i[p] && in_rng(widx_i[p])) begin
          st_q[widx_i[p][LW-1:0]]   <= wstate_i[p];
          data_q[widx_i[p][LW-1:0]] <= wdata_i[p];
          head_q[widx_i[p][LW-1:0]] <= whead_i[p];
          tail_q[widx_i[p][LW-1:0]] <= wtail_i[p];
          meta_q[widx_i[p][LW-1:0]] <= wmeta_i[p];
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      if (in_rng(ridx_i[r])) begin
        rstate_o[r] = st_q[ridx_i[r][LW-1:0]];
        rdata_o[r]  = data_q[ridx_i[r][LW-1:0]];
        rhead_o[r]  = head_q[ridx_i[r][LW-1:0]];
        rtail_o[r]  = tail_q[ridx_i[r][LW-1:0]];
        rmeta_o[r]  = meta_q[ridx_i[r][LW-1:0]];
      end else begin
        rstate_o[r] = ST_EMPTY;
        rdata_o[r]  = '0;
        rhead_o[r]  = '1;
        rtail_o[r]  = '1;
        rmeta_o[r]  = '0;
      end
    end
    if (in_rng(qidx_i)) begin
      qstate_o = st_q[qidx_i[LW-1:0]];
      qdata_o  = data_q[qidx_i[LW-1:0]];
    end else begin
      qstate_o = ST_EMPTY;
      qdata_o  = '0;
    end
  end
endmodule

// File: rtl/srf_wr_check.sv
module srf_wr_check
  import srf_pkg::*;
#(
  parameter int TID_W  = 4,
  parameter int META_W = 4
) (
  input  logic              valid_i,
  input  logic              in_range_i,
  input  logic              dup_i,
  input  logic [1:0]        new_state_i,
  input  logic [TID_W-1:0]  new_head_i,
  input  logic [META_W-1:0] new_meta_i,
  input  logic              from_mem_i,
  input  logic [1:0]        old_state_i,
  input  logic [TID_W-1:0]  old_head_i,
  input  logic [META_W-1:0] old_meta_i,
  output logic              ok_o,
  output logic              wake_o,
  output logic [ERR_W-1:0]  err_o
);
  logic live, head_bad, illegal, meta_bad, new_full;

  always_comb begin
    new_full = (new_state_i == ST_FULL);
    live     = valid_i && in_range_i && !dup_i;
    head_bad = ((new_state_i == ST_EMPTY) || (new_state_i == ST_PENDING)) && (new_head_i != '1);
    illegal  = (old_state_i == ST_WAITING) && (new_state_i == ST_EMPTY);
    // load-pending entries are owned by the memory path
    meta_bad = (old_state_i != ST_FULL) && (old_meta_i != '0) && !from_mem_i &&
               (new_full || (new_meta_i != old_meta_i));

    err_o              = '0;
    err_o[ERR_RANGE]   = valid_i && !in_range_i;
    err_o[ERR_DUP]     = valid_i && in_range_i && dup_i;
    err_o[ERR_HEAD]    = live && head_bad;
    err_o[ERR_ILLEGAL] = live && illegal;
    err_o[ERR_META]    = live && meta_bad;

    ok_o   = valid_i && (err_o == '0);
    wake_o = ok_o && new_full && (old_state_i == ST_WAITING) && (old_head_i != '1);
  end
endmodule

// File: rtl/srf_wake_arb.sv
module srf_wake_arb #(
  parameter int NWP   = 2,
  parameter int TID_W = 4
) (
  input  logic [NWP-1:0]             req_i,
  input  logic [NWP-1:0][TID_W-1:0]  head_i,
  input  logic [NWP-1:0][TID_W-1:0]  tail_i,
  output logic [NWP-1:0]             gnt_o,
  output logic                       valid_o,
  output logic [TID_W-1:0]           head_o,
  output logic [TID_W-1:0]           tail_o
);
  always_comb begin
    gnt_o   = '0;
    valid_o = 1'b0;
    head_o  = '1;
    tail_o  = '1;
    for (int p = 0; p < NWP; p++) begin
      if (req_i[p] && !valid_o) begin
        valid_o  = 1'b1;
        gnt_o[p] = 1'b1;
        head_o   = head_i[p];
        tail_o   = tail_i[p];
      end
    end
  end
endmodule

// File: rtl/dfsync_regfile.sv
module dfsync_regfile
  import srf_pkg::*;
#(
  parameter int NWP       = 2,
  parameter int DEPTH_INT = 16,
  parameter int DEPTH_FLT = 12,
  parameter int DATA_W    = 32,
  parameter int TID_W     = 4,
  parameter int META_W    = 4,
  parameter int IDX_W     = $clog2((DEPTH_INT > DEPTH_FLT) ? DEPTH_INT : DEPTH_FLT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NWP-1:0]              wr_valid_i,
  input  logic [NWP-1:0]              wr_type_i,
  input  logic [NWP-1:0][IDX_W-1:0]   wr_idx_i,
  input  logic [NWP-1:0][1:0]         wr_state_i,
  input  logic [NWP-1:0][DATA_W-1:0]  wr_data_i,
  input  logic [NWP-1:0][TID_W-1:0]   wr_head_i,
  input  logic [NWP-1:0][TID_W-1:0]   wr_tail_i,
  input  logic [NWP-1:0][META_W-1:0]  wr_meta_i,
  input  logic [NWP-1:0]              wr_mem_i,
  output logic [NWP-1:0]              wr_ready_o,
  output logic                        wake_valid_o,
  input  logic                        wake_ready_i,
  output logic [TID_W-1:0]            wake_head_o,
  output logic [TID_W-1:0]            wake_tail_o,
  input  logic                        rrd_req_i,
  input  logic                        rrd_type_i,
  input  logic [IDX_W-1:0]            rrd_idx_i,
  output logic                        rrd_valid_o,
  output logic [DATA_W-1:0]           rrd_data_o,
  input  logic                        lk_type_i,
  input  logic [IDX_W-1:0]            lk_idx_i,
  output logic [1:0]                  lk_state_o,
  output logic [DATA_W-1:0]           lk_data_o,
  output logic [TID_W-1:0]            lk_head_o,
  output logic [TID_W-1:0]            lk_tail_o,
  output logic [META_W-1:0]           lk_meta_o,
  input  logic                        clr_err_i,
  output logic [ERR_W-1:0]            err_o,
  output logic                        warn_o
);
  localparam int NRD = NWP + 1;  // one read per write port plus lookup
  localparam int NB  = 2;
  localparam int LK  = NWP;
  localparam logic [IDX_W:0] DI_L = (IDX_W+1)'(DEPTH_INT);
  localparam logic [IDX_W:0] DF_L = (IDX_W+1)'(DEPTH_FLT);

  logic [NRD-1:0][IDX_W-1:0]  ridx;
  logic [NB-1:0][NWP-1:0]     bank_we;
  logic [NB-1:0][NRD-1:0][1:0]        b_st;
  logic [NB-1:0][NRD-1:0][DATA_W-1:0] b_data;
  logic [NB-1:0][NRD-1:0][TID_W-1:0]  b_head;
  logic [NB-1:0][NRD-1:0][TID_W-1:0]  b_tail;
  logic [NB-1:0][NRD-1:0][META_W-1:0] b_meta;
  logic [NB-1:0][1:0]                 q_st;
  logic [NB-1:0][DATA_W-1:0]          q_data;

  logic [NWP-1:0]              in_rng, dup, ok, need_wake, gnt, commit;
  logic [NWP-1:0][1:0]         old_st;
  logic [NWP-1:0][TID_W-1:0]   old_head, old_tail;
  logic [NWP-1:0][META_W-1:0]  old_meta;
  logic [NWP-1:0][ERR_W-1:0]   port_err;
  logic [ERR_W-1:0]            err_set, err_q;
  logic                        warn_q, rrd_valid_q;
  logic [DATA_W-1:0]           rrd_data_q;

  always_comb begin
    for (int p = 0; p < NWP; p++) ridx[p] = wr_idx_i[p];
    ridx[LK] = lk_idx_i;
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      srf_bank #(
        .DEPTH (b == 0 ? DEPTH_INT : DEPTH_FLT),
        .IDX_W (IDX_W), .DATA_W(DATA_W), .TID_W(TID_W), .META_W(META_W),
        .NWP   (NWP), .NRD(NRD)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bank_we[b]),
        .widx_i  (wr_idx_i),
        .wstate_i(wr_state_i),
        .wdata_i (wr_data_i),
        .whead_i (wr_head_i),
        .wtail_i (wr_tail_i),
        .wmeta_i (wr_meta_i),
        .ridx_i  (ridx),
        .rstate_o(b_st[b]),
        .rdata_o (b_data[b]),
        .rhead_o (b_head[b]),
        .rtail_o (b_tail[b]),
        .rmeta_o (b_meta[b]),
        .qidx_i  (rrd_idx_i),
        .qstate_o(q_st[b]),
        .qdata_o (q_data[b])
      );
    end

    for (genvar p = 0; p < NWP; p++) begin : g_chk
      srf_wr_check #(.TID_W(TID_W), .META_W(META_W)) u_chk (
        .valid_i    (wr_valid_i[p]),
        .in_range_i (in_rng[p]),
        .dup_i      (dup[p]),
        .new_state_i(wr_state_i[p]),
        .new_head_i (wr_head_i[p]),
        .new_meta_i (wr_meta_i[p]),
        .from_mem_i (wr_mem_i[p]),
        .old_state_i(old_st[p]),
        .old_head_i (old_head[p]),
        .old_meta_i (old_meta[p]),
        .ok_o       (ok[p]),
        .wake_o     (need_wake[p]),
        .err_o      (port_err[p])
      );
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < NWP; p++) begin
      in_rng[p]   = wr_type_i[p] ? ({1'b0, wr_idx_i[p]} < DF_L) : ({1'b0, wr_idx_i[p]} < DI_L);
      old_st[p]   = b_st[wr_type_i[p]][p];
      old_head[p] = b_head[wr_type_i[p]][p];
      old_tail[p] = b_tail[wr_type_i[p]][p];
      old_meta[p] = b_meta[wr_type_i[p]][p];
      dup[p]      = 1'b0;
      for (int j = 0; j < p; j++) begin
        if (wr_valid_i[j] && (wr_type_i[j] == wr_type_i[p]) && (wr_idx_i[j] == wr_idx_i[p]))
          dup[p] = 1'b1;
      end
    end
  end

  srf_wake_arb #(.NWP(NWP), .TID_W(TID_W)) u_arb (
    .req_i  (need_wake),
    .head_i (old_head),
    .tail_i (old_tail),
    .gnt_o  (gnt),
    .valid_o(wake_valid_o),
    .head_o (wake_head_o),
    .tail_o (wake_tail_o)
  );

  always_comb begin
    err_set = '0;
    for (int p = 0; p < NWP; p++) begin
      commit[p]     = ok[p] && (!need_wake[p] || (gnt[p] && wake_ready_i));
      wr_ready_o[p] = !(need_wake[p] && !(gnt[p] && wake_ready_i));
      bank_we[0][p] = commit[p] && !wr_type_i[p];
      bank_we[1][p] = commit[p] &&  wr_type_i[p];
      err_set       = err_set | port_err[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= '0;
      warn_q      <= 1'b0;
      rrd_valid_q <= 1'b0;
      rrd_data_q  <= '0;
    end else begin
      err_q       <= clr_err_i ? '0 : (err_q | err_set);
      rrd_valid_q <= rrd_req_i;
      if (rrd_req_i) rrd_data_q <= (q_st[rrd_type_i] == ST_FULL) ? q_data[rrd_type_i] : '0;
      if (clr_err_i) warn_q <= 1'b0;
      else if (rrd_req_i && (q_st[rrd_type_i] != ST_FULL)) warn_q <= 1'b1;
    end
  end

  assign err_o       = err_q;
  assign warn_o      = warn_q;
  assign rrd_valid_o = rrd_valid_q;
  assign rrd_data_o  = rrd_data_q;
  assign lk_state_o  = b_st[lk_type_i][LK];
  assign lk_data_o   = b_data[lk_type_i][LK];
  assign lk_head_o   = b_head[lk_type_i][LK];
  assign lk_tail_o   = b_tail[lk_type_i][LK];
  assign lk_meta_o   = b_meta[lk_type_i][LK];
endmodule

// File: rtl/dfsync_regfile_chk.sv
module dfsync_regfile_chk #(
  parameter int NWP       = 2,
  parameter int DEPTH_FLT = 12,
  parameter int DATA_W    = 32,
  parameter int TID_W     = 4,
  parameter int IDX_W     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NWP-1:0]             wr_valid_i,
  input logic [NWP-1:0]             wr_type_i,
  input logic [NWP-1:0][IDX_W-1:0]  wr_idx_i,
  input logic [NWP-1:0]             wr_ready_o,
  input logic                       wake_valid_o,
  input logic                       wake_ready_i,
  input logic [TID_W-1:0]           wake_head_o,
  input logic                       rrd_req_i,
  input logic                       rrd_valid_o,
  input logic [DATA_W-1:0]          rrd_data_o,
  input logic                       clr_err_i,
  input logic [4:0]                 err_o,
  input logic                       warn_o
);
  localparam logic [IDX_W:0] DF_L = (IDX_W+1)'(DEPTH_FLT);

  p_wake_head_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |-> (wake_head_o != '1));

  p_wake_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_valid_o && !wake_ready_i) |-> ((wr_ready_o & wr_valid_i) != wr_valid_i));

  p_range_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i[0] && wr_type_i[0] && ({1'b0, wr_idx_i[0]} >= DF_L) && !clr_err_i) |=> err_o[0]);

  p_rd_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrd_req_i |=> rrd_valid_o);

  p_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_o) |-> (rrd_valid_o && (rrd_data_o == '0)));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i |=> ((err_o == '0) && !warn_o));

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_err_i |=> (((err_o & $past(err_o)) == $past(err_o)) && (warn_o || !$past(warn_o))));
endmodule

bind dfsync_regfile dfsync_regfile_chk #(
  .NWP(NWP), .DEPTH_FLT(DEPTH_FLT), .DATA_W(DATA_W), .TID_W(TID_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_dfsync_regfile.sv
module sim_dfsync_regfile;
  localparam int NWP = 2, DW = 32, TW = 4, MW = 4, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NWP-1:0] wr_valid, wr_type, wr_mem, wr_ready;
  logic [NWP-1:0][IW-1:0] wr_idx;
  logic [NWP-1:0][1:0] wr_state;
  logic [NWP-1:0][DW-1:0] wr_data;
  logic [NWP-1:0][TW-1:0] wr_head, wr_tail;
  logic [NWP-1:0][MW-1:0] wr_meta;
  logic wake_valid, wake_ready;
  logic [TW-1:0] wake_head, wake_tail;
  logic rrd_req, rrd_type, rrd_valid;
  logic [IW-1:0] rrd_idx;
  logic [DW-1:0] rrd_data;
  logic lk_type;
  logic [IW-1:0] lk_idx;
  logic [1:0] lk_state;
  logic [DW-1:0] lk_data;
  logic [TW-1:0] lk_head, lk_tail;
  logic [MW-1:0] lk_meta;
  logic clr_err, warn;
  logic [4:0] err;

  dfsync_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_type_i(wr_type), .wr_idx_i(wr_idx), .wr_state_i(wr_state),
    .wr_data_i(wr_data), .wr_head_i(wr_head), .wr_tail_i(wr_tail), .wr_meta_i(wr_meta),
    .wr_mem_i(wr_mem), .wr_ready_o(wr_ready),
    .wake_valid_o(wake_valid), .wake_ready_i(wake_ready), .wake_head_o(wake_head), .wake_tail_o(wake_tail),
    .rrd_req_i(rrd_req), .rrd_type_i(rrd_type), .rrd_idx_i(rrd_idx), .rrd_valid_o(rrd_valid), .rrd_data_o(rrd_data),
    .lk_type_i(lk_type), .lk_idx_i(lk_idx), .lk_state_o(lk_state), .lk_data_o(lk_data),
    .lk_head_o(lk_head), .lk_tail_o(lk_tail), .lk_meta_o(lk_meta),
    .clr_err_i(clr_err), .err_o(err), .warn_o(warn)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // {req[4], type, idx[4], state[2], data[16], head[4], meta[4], mem, exp_err[5], exp_state[2], exp_data[16]}
  localparam int NV = 13;
  localparam logic [58:0] VEC [NV] = '{
    {4'd2,  1'b0, 4'd1,  2'd1, 16'h0000, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd1, 16'h0000}, // R2 int r1 pending
    {4'd2,  1'b0, 4'd1,  2'd2, 16'h0000, 4'h3, 4'h0, 1'b0, 5'b00000, 2'd2, 16'h0000}, // R2 int r1 waiting
    {4'd4,  1'b0, 4'd1,  2'd0, 16'h0000, 4'hF, 4'h0, 1'b0, 5'b00010, 2'd2, 16'h0000}, // R4 waiting->empty
    {4'd3,  1'b0, 4'd1,  2'd3, 16'h00AB, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd3, 16'h00AB}, // R3 fill with wake
    {4'd2,  1'b1, 4'd1,  2'd3, 16'h0055, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd3, 16'h0055}, // R2 float bank
    {4'd5,  1'b0, 4'd2,  2'd1, 16'h0000, 4'h7, 4'h0, 1'b0, 5'b00100, 2'd0, 16'h0000}, // R5 bad head
    {4'd7,  1'b1, 4'd13, 2'd3, 16'h0001, 4'hF, 4'h0, 1'b0, 5'b00001, 2'd0, 16'h0000}, // R7 range
    {4'd6,  1'b0, 4'd3,  2'd1, 16'h0000, 4'hF, 4'h5, 1'b0, 5'b00000, 2'd1, 16'h0000}, // R6 load pending
    {4'd6,  1'b0, 4'd3,  2'd3, 16'h0009, 4'hF, 4'h5, 1'b0, 5'b01000, 2'd1, 16'h0000}, // R6 non-memory fill
    {4'd6,  1'b0, 4'd3,  2'd3, 16'h0009, 4'hF, 4'h5, 1'b1, 5'b00000, 2'd3, 16'h0009}, // R6 memory fill
    {4'd11, 1'b0, 4'd4,  2'd2, 16'h0000, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd2, 16'h0000}, // R11 waiting no head
    {4'd11, 1'b0, 4'd4,  2'd3, 16'h0044, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd3, 16'h0044}, // R11 fill no wake
    {4'd12, 1'b0, 4'd4,  2'd0, 16'h0000, 4'hF, 4'h0, 1'b0, 5'b00000, 2'd0, 16'h0000}  // R12 full->empty
  };

  task automatic wr(input int p, input logic t, input logic [IW-1:0] i, input logic [1:0] s,
                    input logic [DW-1:0] d, input logic [TW-1:0] h, input logic [TW-1:0] tl,
                    input logic [MW-1:0] m, input logic mem);
    wr_valid[p] = 1'b1; wr_type[p] = t; wr_idx[p] = i; wr_state[p] = s;
    wr_data[p] = d; wr_head[p] = h; wr_tail[p] = tl; wr_meta[p] = m; wr_mem[p] = mem;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wr_valid = '0; wr_type = '0; wr_idx = '0; wr_state = '0; wr_data = '0;
    wr_head = '1; wr_tail = '1; wr_meta = '0; wr_mem = '0;
    wake_ready = 1'b1; rrd_req = 1'b0; rrd_type = 1'b0; rrd_idx = '0;
    lk_type = 1'b0; lk_idx = '0; clr_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 err", 64'(err), 0);
    chk("R1 warn", 64'(warn), 0);
    chk("R1 wake", 64'(wake_valid), 0);
    chk("R1 rrd_valid", 64'(rrd_valid), 0);
    chk("R1 state", 64'(lk_state), 0);
    chk("R1 head", 64'(lk_head), 64'hF);
    chk("R1 data", 64'(lk_data), 0);

    // table walk on port 0
    for (int v = 0; v < NV; v++) begin
      clear_flags();
      wr(0, VEC[v][54], VEC[v][53:50], VEC[v][49:48], 32'(VEC[v][47:32]), VEC[v][31:28],
         VEC[v][31:28], VEC[v][27:24], VEC[v][23]);
      lk_type = VEC[v][54]; lk_idx = VEC[v][53:50];
      #2;
      chk($sformatf("R%0d v%0d ready", VEC[v][58:55], v), 64'(wr_ready[0]), 1);
      @(negedge clk);
      wr_valid = '0;
      chk($sformatf("R%0d v%0d err", VEC[v][58:55], v), 64'(err), 64'(VEC[v][22:18]));
      chk($sformatf("R%0d v%0d state", VEC[v][58:55], v), 64'(lk_state), 64'(VEC[v][17:16]));
      chk($sformatf("R%0d v%0d data", VEC[v][58:55], v), 64'(lk_data), 64'(VEC[v][15:0]));
    end

    // R2 bank independence: int r1 still holds its fill
    lk_type = 1'b0; lk_idx = 4'd1; #1;
    chk("R2 int r1 untouched", 64'(lk_data), 64'hAB);
    lk_idx = 4'd3; #1;
    chk("R6 meta kept", 64'(lk_meta), 5);

    // R3 stalled wake-up
    clear_flags();
    wr(0, 1'b0, 4'd5, 2'd2, 0, 4'd2, 4'd6, 0, 1'b0);
    lk_type = 1'b0; lk_idx = 4'd5;
    @(negedge clk);
    chk("R2 tail", 64'(lk_tail), 6);
    wr(0, 1'b0, 4'd5, 2'd3, 32'h77, 4'hF, 4'hF, 0, 1'b0);
    wake_ready = 1'b0;
    #2;
    chk("R3 wake valid", 64'(wake_valid), 1);
    chk("R3 wake head", 64'(wake_head), 2);
    chk("R3 wake tail", 64'(wake_tail), 6);
    chk("R3 stall ready", 64'(wr_ready[0]), 0);
    @(negedge clk);
    chk("R3 held state", 64'(lk_state), 2);
    wake_ready = 1'b1;
    #2;
    chk("R3 ready after grant", 64'(wr_ready[0]), 1);
    @(negedge clk);
    wr_valid = '0;
    chk("R3 filled state", 64'(lk_state), 3);
    chk("R3 filled data", 64'(lk_data), 64'h77);
    chk("R3 no error", 64'(err), 0);

    // R8 same register on both ports
    clear_flags();
    wr(0, 1'b0, 4'd6, 2'd3, 32'h11, 4'hF, 4'hF, 0, 1'b0);
    wr(1, 1'b0, 4'd6, 2'd3, 32'h22, 4'hF, 4'hF, 0, 1'b0);
    lk_idx = 4'd6;
    @(negedge clk);
    wr_valid = '0;
    chk("R8 dup flag", 64'(err), 64'h10);
    chk("R8 lower port wins", 64'(lk_data), 64'h11);

    // R2 two ports, two banks, same cycle
    clear_flags();
    wr(0, 1'b0, 4'd7, 2'd1, 0, 4'hF, 4'hF, 0, 1'b0);
    wr(1, 1'b1, 4'd7, 2'd3, 32'h99, 4'hF, 4'hF, 0, 1'b0);
    @(negedge clk);
    wr_valid = '0;
    lk_type = 1'b0; lk_idx = 4'd7; #1;
    chk("R2 dual int", 64'(lk_state), 1);
    lk_type = 1'b1; #1;
    chk("R2 dual flt", 64'(lk_data), 64'h99);
    chk("R2 dual err", 64'(err), 0);

    // R9 remote reads
    rrd_req = 1'b1; rrd_type = 1'b0; rrd_idx = 4'd6;
    @(negedge clk);
    rrd_idx = 4'd8;
    chk("R9 full valid", 64'(rrd_valid), 1);
    chk("R9 full data", 64'(rrd_data), 64'h11);
    chk("R9 no warn", 64'(warn), 0);
    @(negedge clk);
    rrd_req = 1'b0;
    chk("R9 empty data", 64'(rrd_data), 0);
    chk("R9 warn", 64'(warn), 1);

    // R10 sticky flags and clear
    wr(0, 1'b1, 4'd14, 2'd3, 0, 4'hF, 4'hF, 0, 1'b0);
    @(negedge clk);
    wr_valid = '0;
    repeat (2) @(negedge clk);
    chk("R10 err sticky", 64'(err), 1);
    chk("R10 warn sticky", 64'(warn), 1);
    clr_err = 1'b1;
    wr(0, 1'b1, 4'd15, 2'd3, 0, 4'hF, 4'hF, 0, 1'b0);
    @(negedge clk);
    clr_err = 1'b0; wr_valid = '0;
    chk("R10 clear wins", 64'(err), 0);
    chk("R10 warn cleared", 64'(warn), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule